// File: doc/BRIEF.md
# Inter-core doorbell mailbox

This block gives a small multicore cluster a way for one core to ring another. Each core owns one mailbox word of 32 doorbell bits. Any bus master may raise bits in any core's mailbox through a set window. The core that owns the mailbox reads its pending doorbells through a clear window and acknowledges them by writing ones to the same address. The mailbox is a bitmap: posting a bit that is already pending merges with it, and nothing queues.

Each core has an interrupt-enable flag. The block drives a per-core doorbell interrupt toward the local interrupt router while the flag is set and the mailbox holds any bit. It also presents, per core, the index of the lowest pending doorbell. The receiving core is expected to service that doorbell first and then clear it.

Several bus ports (parameter `NUM_PORTS`) can reach the mailboxes in the same cycle. This models cores that post and acknowledge concurrently. Every port has the same address map.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every mailbox and every enable flag is zero, `irqOut` is all zero, `nextIdx` is zero and every `busRdata` slice is zero.
- R2: A write to the set register of core c (address `SET_BASE + 16*c`, default 0x00, 0x10, 0x20, 0x30) ORs the write data into that core's mailbox. The new value is visible from the next cycle. Writes from several ports to the same mailbox in one cycle all merge.
- R3: A read of the clear register of core c (address `CLR_BASE + 16*c`, default 0x40 to 0x70) returns the mailbox value as it stood before the request's clock edge. The value appears on that port's `busRdata` slice for exactly the following cycle. A read of a set register or of an unmapped address returns zero, and `busRdata` is zero in any cycle that does not follow a read.
- R4: A write to the clear register of core c clears exactly the mailbox bits written as one and leaves all other bits unchanged.
- R5: When a set and a clear reach the same mailbox in the same cycle, any bit present in both masks ends up set.
- R6: The enable flag of core c is bit 0 of the register at `EN_BASE + 4*c` (default 0x80 to 0x8C). Writing it stores write-data bit 0, and reading it returns the flag in bit 0 with zeros above. `irqOut[c]` is high exactly while the flag is one and mailbox c is nonzero.
- R7: `nextIdx[5*c +: 5]` gives the position of the lowest set bit of mailbox c, or 0 when the mailbox is empty.
- R8: Accesses to addresses outside the three windows, or not aligned to a register, change no state and read as zero.
- R9: When two ports write the same enable register in one cycle, the lower-numbered port's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | NUM_PORTS | Per-port access request |
| busWrite | input | NUM_PORTS | Per-port write (1) or read (0) |
| busAddr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p in slice p |
| busWdata | input | NUM_PORTS*MBX_W | Per-port write data |
| busRdata | output | NUM_PORTS*MBX_W | Per-port read data, one cycle after the read |
| irqOut | output | NUM_CORES | Per-core doorbell interrupt |
| nextIdx | output | NUM_CORES*IDX_W | Per-core index of the lowest pending doorbell |

## Verification
The bench builds the block with its defaults: four cores, two bus ports, 32-bit mailboxes and an 8-bit address. With two ports, the bench can make a set and a clear collide on one mailbox and can make two enable writes compete, so R5 and R9 are exercised. Walking a single doorbell across all 32 positions covers every output of the lowest-bit finder. A long stretch of pseudo-random traffic mixes every window, both ports and unmapped addresses, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

  // Width of the core selector carried in a strobe (up to 16 cores)
  localparam int CORE_SEL_W = 4;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2,
    WIN_EN   = 2'd3
  } winSel_e;

  // One decoded bus access, handed from control to datapath
  typedef struct packed {
    logic                  valid;
    logic                  isWrite;
    winSel_e               win;
    logic [CORE_SEL_W-1:0] core;
  } busStrobe_t;

endpackage

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int ADDR_W      = 8,
  parameter int SET_BASE    = 'h00,
  parameter int CLR_BASE    = 'h40,
  parameter int EN_BASE     = 'h80,
  parameter int CORE_STRIDE = 16,
  parameter int EN_STRIDE   = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  always_comb begin
    strobe         = '0;
    strobe.win     = WIN_NONE;
    strobe.valid   = busValid;
    strobe.isWrite = busWrite;
    if (busValid) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (busAddr == ADDR_W'(SET_BASE + c * CORE_STRIDE)) begin
          strobe.win  = WIN_SET;
          strobe.core = CORE_SEL_W'(c);
        end
        if (busAddr == ADDR_W'(CLR_BASE + c * CORE_STRIDE)) begin
          strobe.win  = WIN_CLR;
          strobe.core = CORE_SEL_W'(c);
        end
        if (busAddr == ADDR_W'(EN_BASE + c * EN_STRIDE)) begin
          strobe.win  = WIN_EN;
          strobe.core = CORE_SEL_W'(c);
        end
      end
    end
  end

  // R8: a decoded window never names a core that does not exist
  assert_core_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.win != WIN_NONE) |-> (int'(strobe.core) < NUM_CORES));

  // R8: nothing is decoded without a request
  assert_no_ghost_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busValid) |-> (strobe.win == WIN_NONE));

endmodule

// File: rtl/mbx_datapath.sv
`timescale 1ns/1ps
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 2,
  parameter int MBX_W     = 32,
  localparam int IDX_W    = $clog2(MBX_W)
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobe_t                 strobes [NUM_PORTS],
  input  logic [NUM_PORTS*MBX_W-1:0] wdata,
  output logic [NUM_PORTS*MBX_W-1:0] rdata,
  output logic [NUM_CORES-1:0]       irqOut,
  output logic [NUM_CORES*IDX_W-1:0] nextIdx
);

  logic [MBX_W-1:0] mbxQ    [NUM_CORES];
  logic             enQ     [NUM_CORES];
  logic             enNext  [NUM_CORES];
  logic             enWr    [NUM_CORES];
  logic [MBX_W-1:0] setMask [NUM_CORES];
  logic [MBX_W-1:0] clrMask [NUM_CORES];
  logic [MBX_W-1:0] rdNext  [NUM_PORTS];

  function automatic logic [IDX_W-1:0] lowestSet(input logic [MBX_W-1:0] v);
    lowestSet = '0;
    for (int b = MBX_W - 1; b >= 0; b--) begin
      if (v[b]) lowestSet = IDX_W'(b);
    end
  endfunction

  // Merge write strobes from all ports; port 0 is applied last so it wins enables
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      setMask[c] = '0;
      clrMask[c] = '0;
      enWr[c]    = 1'b0;
      enNext[c]  = enQ[c];
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (strobes[p].valid && strobes[p].isWrite &&
            strobes[p].core == CORE_SEL_W'(c)) begin
          case (strobes[p].win)
            WIN_SET: setMask[c] = setMask[c] | wdata[p*MBX_W +: MBX_W];
            WIN_CLR: clrMask[c] = clrMask[c] | wdata[p*MBX_W +: MBX_W];
            WIN_EN: begin
              enNext[c] = wdata[p*MBX_W];
              enWr[c]   = 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // Read mux: clear window shows the mailbox, enable window shows the flag
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      rdNext[p] = '0;
      if (strobes[p].valid && !strobes[p].isWrite) begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (strobes[p].core == CORE_SEL_W'(c)) begin
            if (strobes[p].win == WIN_CLR) rdNext[p] = mbxQ[c];
            if (strobes[p].win == WIN_EN)  rdNext[p] = MBX_W'(enQ[c]);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        mbxQ[c] <= '0;
        enQ[c]  <= 1'b0;
      end
      rdata <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        // set after clear: overlapping bits stay set
        mbxQ[c] <= (mbxQ[c] & ~clrMask[c]) | setMask[c];
        enQ[c]  <= enNext[c];
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        rdata[p*MBX_W +: MBX_W] <= rdNext[p];
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign irqOut[c]                   = enQ[c] & (|mbxQ[c]);
    assign nextIdx[c*IDX_W +: IDX_W]   = lowestSet(mbxQ[c]);

    // R5: every posted bit is present after the edge, whatever was cleared
    assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
      (|setMask[c]) |=> ((mbxQ[c] & $past(setMask[c])) == $past(setMask[c])));

    // R4: with no clear, no pending bit disappears
    assert_hold_without_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      (clrMask[c] == '0) |=> ((mbxQ[c] & $past(mbxQ[c])) == $past(mbxQ[c])));

    // R6: interrupt rises only after a post or an enable write
    assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqOut[c]) |-> $past((|setMask[c]) || enWr[c]));

    // R6: interrupt drops only after a clear or an enable write
    assert_irq_fall_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqOut[c]) |-> $past((|clrMask[c]) || enWr[c]));
  end

endmodule

// File: rtl/mbx_doorbell.sv
`timescale 1ns/1ps
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_PORTS   = 2,
  parameter int MBX_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SET_BASE    = 'h00,
  parameter int CLR_BASE    = 'h40,
  parameter int EN_BASE     = 'h80,
  parameter int CORE_STRIDE = 16,
  parameter int EN_STRIDE   = 4,
  localparam int IDX_W      = $clog2(MBX_W)
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        busValid,
  input  logic [NUM_PORTS-1:0]        busWrite,
  input  logic [NUM_PORTS*ADDR_W-1:0] busAddr,
  input  logic [NUM_PORTS*MBX_W-1:0]  busWdata,
  output logic [NUM_PORTS*MBX_W-1:0]  busRdata,
  output logic [NUM_CORES-1:0]        irqOut,
  output logic [NUM_CORES*IDX_W-1:0]  nextIdx
);

  busStrobe_t strobes [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbx_ctrl #(
      .NUM_CORES  (NUM_CORES),
      .ADDR_W     (ADDR_W),
      .SET_BASE   (SET_BASE),
      .CLR_BASE   (CLR_BASE),
      .EN_BASE    (EN_BASE),
      .CORE_STRIDE(CORE_STRIDE),
      .EN_STRIDE  (EN_STRIDE)
    ) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .busValid(busValid[p]),
      .busWrite(busWrite[p]),
      .busAddr (busAddr[p*ADDR_W +: ADDR_W]),
      .strobe  (strobes[p])
    );

    // R3: read data is zero in any cycle that does not follow a read
    assert_rd_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
      !(busValid[p] && !busWrite[p]) |=> (busRdata[p*MBX_W +: MBX_W] == '0));
  end

  mbx_datapath #(
    .NUM_CORES(NUM_CORES),
    .NUM_PORTS(NUM_PORTS),
    .MBX_W    (MBX_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irqOut (irqOut),
    .nextIdx(nextIdx)
  );

endmodule

// File: tb/mbx_doorbell_test.sv
`timescale 1ns/1ps
module mbx_doorbell_test;

  localparam int NC = 4;
  localparam int NP = 2;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int IW = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NP-1:0]     busValid = '0;
  logic [NP-1:0]     busWrite = '0;
  logic [NP*AW-1:0]  busAddr  = '0;
  logic [NP*W-1:0]   busWdata = '0;
  logic [NP*W-1:0]   busRdata;
  logic [NC-1:0]     irqOut;
  logic [NC*IW-1:0]  nextIdx;

  int vectors = 0;
  int fails   = 0;
  string phaseTag = "R1";
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbx_doorbell uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .nextIdx(nextIdx)
  );

  // ---------------- reference model ----------------
  logic [W-1:0] mMbx [NC];
  logic         mEn  [NC];
  logic [W-1:0] mRd  [NP];

  // 0 none, 1 set, 2 clear, 3 enable
  function automatic int decodeAddr(input logic [AW-1:0] a, output int core);
    core = 0;
    if (a < 8'h40 && a[3:0] == 4'h0) begin core = int'(a) / 16; return 1; end
    if (a >= 8'h40 && a < 8'h80 && a[3:0] == 4'h0) begin core = (int'(a) - 'h40) / 16; return 2; end
    if (a >= 8'h80 && a < 8'h90 && a[1:0] == 2'b00) begin core = (int'(a) - 'h80) / 4; return 3; end
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NC; c++) begin mMbx[c] = '0; mEn[c] = 1'b0; end
      for (int p = 0; p < NP; p++) mRd[p] = '0;
    end else begin
      logic [W-1:0] setAcc [NC];
      logic [W-1:0] clrAcc [NC];
      logic         enNew  [NC];
      for (int c = 0; c < NC; c++) begin setAcc[c] = '0; clrAcc[c] = '0; enNew[c] = mEn[c]; end
      for (int p = NP - 1; p >= 0; p--) begin
        int core;
        int kind;
        logic [W-1:0] d;
        kind = decodeAddr(busAddr[p*AW +: AW], core);
        d = busWdata[p*W +: W];
        mRd[p] = '0;
        if (busValid[p]) begin
          if (busWrite[p]) begin
            if (kind == 1) setAcc[core] |= d;
            if (kind == 2) clrAcc[core] |= d;
            if (kind == 3) enNew[core] = d[0];
          end else begin
            if (kind == 2) mRd[p] = mMbx[core];
            if (kind == 3) mRd[p] = {31'b0, mEn[core]};
          end
        end
      end
      for (int c = 0; c < NC; c++) begin
        mMbx[c] = (mMbx[c] & ~clrAcc[c]) | setAcc[c];
        mEn[c]  = enNew[c];
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      for (int c = 0; c < NC; c++) begin
        logic expIrq;
        logic [IW-1:0] expIdx;
        expIrq = mEn[c] && (mMbx[c] != 0);
        expIdx = '0;
        for (int b = 0; b < W; b++) begin
          if (mMbx[c][b]) begin expIdx = IW'(b); break; end
        end
        vectors++;
        if (irqOut[c] !== expIrq) begin
          fails++;
          $display("FAIL %s/R6 irq core %0d: got %b expected %b", phaseTag, c, irqOut[c], expIrq);
        end
        vectors++;
        if (nextIdx[c*IW +: IW] !== expIdx) begin
          fails++;
          $display("FAIL %s/R7 nextIdx core %0d: got %0d expected %0d", phaseTag, c, nextIdx[c*IW +: IW], expIdx);
        end
      end
      for (int p = 0; p < NP; p++) begin
        vectors++;
        if (busRdata[p*W +: W] !== mRd[p]) begin
          fails++;
          $display("FAIL %s/R3 rdata port %0d: got %h expected %h", phaseTag, p, busRdata[p*W +: W], mRd[p]);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic putPort(input int p, input bit wr, input logic [AW-1:0] a, input logic [W-1:0] d);
    busValid[p] = 1'b1;
    busWrite[p] = wr;
    busAddr[p*AW +: AW] = a;
    busWdata[p*W +: W] = d;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    busValid = '0;
    busWrite = '0;
    busAddr  = '0;
    busWdata = '0;
  endtask

  task automatic readAll();
    for (int c = 0; c < NC; c++) begin
      putPort(0, 1'b0, AW'('h40 + 16*c), '0);
      putPort(1, 1'b0, AW'('h80 + 4*c), '0);
      step();
    end
    step();
  endtask

  task automatic report();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] rng;
    rng = 32'h1234_5678;

    // R1: reset state
    phaseTag = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    readAll();

    // R2: two ports post to core 1 in one cycle, then a further post
    phaseTag = "R2";
    putPort(0, 1'b1, 8'h10, 32'h0000_0005);
    putPort(1, 1'b1, 8'h10, 32'h8000_0000);
    step();
    putPort(0, 1'b1, 8'h10, 32'h0000_0100);
    step();
    readAll();

    // R6: enable core 1, read flag, then disable with bit 0 clear
    phaseTag = "R6";
    putPort(1, 1'b1, 8'h84, 32'h0000_0001);
    step();
    readAll();
    putPort(0, 1'b1, 8'h84, 32'hFFFF_FFFE);
    step();
    readAll();
    putPort(0, 1'b1, 8'h84, 32'h0000_0001);
    step();

    // R4: clear exactly the written ones, down to empty
    phaseTag = "R4";
    putPort(1, 1'b1, 8'h50, 32'h0000_0004);
    step();
    readAll();
    putPort(0, 1'b1, 8'h50, 32'hFFFF_FFFF);
    step();
    readAll();

    // R5: set and clear collide on core 2
    phaseTag = "R5";
    putPort(0, 1'b1, 8'h20, 32'h0000_000F);
    step();
    putPort(0, 1'b1, 8'h20, 32'h0000_00F0);
    putPort(1, 1'b1, 8'h60, 32'h0000_00FF);
    step();
    readAll();

    // R7: walk one doorbell across core 3, then stack a lower one
    phaseTag = "R7";
    putPort(0, 1'b1, 8'h8C, 32'h1);
    step();
    for (int b = 0; b < W; b++) begin
      putPort(0, 1'b1, 8'h30, 32'h1 << b);
      step();
      step();
      putPort(1, 1'b1, 8'h70, 32'hFFFF_FFFF);
      step();
    end
    putPort(0, 1'b1, 8'h30, 32'h8001_0000);
    step();
    putPort(1, 1'b1, 8'h30, 32'h0000_0200);
    step();
    step();

    // R8: unmapped and misaligned accesses
    phaseTag = "R8";
    putPort(0, 1'b1, 8'h04, 32'hFFFF_FFFF);
    putPort(1, 1'b1, 8'h44, 32'hFFFF_FFFF);
    step();
    putPort(0, 1'b1, 8'h90, 32'h1);
    putPort(1, 1'b1, 8'hF0, 32'hFFFF_FFFF);
    step();
    putPort(0, 1'b0, 8'h08, '0);
    putPort(1, 1'b0, 8'h30, '0);
    step();
    putPort(0, 1'b1, 8'h81, 32'h1);
    step();
    readAll();

    // R9: both ports write core 0 enable in one cycle
    phaseTag = "R9";
    putPort(0, 1'b1, 8'h80, 32'h1);
    putPort(1, 1'b1, 8'h80, 32'h0);
    step();
    putPort(0, 1'b1, 8'h00, 32'h0000_0040);
    step();
    putPort(0, 1'b1, 8'h80, 32'h0);
    putPort(1, 1'b1, 8'h80, 32'h1);
    step();
    readAll();

    // mixed pseudo-random traffic on every window
    phaseTag = "R2";
    for (int i = 0; i < 2000; i++) begin
      for (int p = 0; p < NP; p++) begin
        logic [AW-1:0] a;
        logic [W-1:0] d;
        int sel;
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        sel = int'(rng[3:0]);
        if (sel < 4)       a = AW'(16*sel);
        else if (sel < 8)  a = AW'('h40 + 16*(sel-4));
        else if (sel < 12) a = AW'('h80 + 4*(sel-8));
        else if (sel == 12) a = 8'h04;
        else if (sel == 13) a = 8'h94;
        else               a = AW'('h40 + 16*rng[5:4]);
        d = rng & {rng[15:0], rng[31:16]};
        if (rng[6]) putPort(p, rng[7], a, d);
      end
      step();
    end
    step();
    report();
  end

endmodule